// File: doc/BRIEF.md
# Parallel Fault Three-Valued Gate Evaluator

This block evaluates a single logic gate over a word of sixteen parallel circuit copies. Lane 0 always holds the fault-free circuit. Each of lanes 1 to 15 holds one faulty copy of the same circuit. Every lane carries a three-valued signal (0, 1 or unknown) in two bits, so one pass gives the gate result for the good circuit and for every fault at once. The result is built only from lane-wise AND, OR and NOT steps.

After the gate is evaluated, stuck-at-0 and stuck-at-1 masks force the output of chosen faulty lanes to a constant. The block then marks every faulty lane whose known value differs from the known value of the good lane. A surrounding fault-simulation engine feeds one gate evaluation per transfer. When the gate drives a primary output, it reads the detection mask to learn which faults the current vector exposes.

Requests enter over a valid/ready channel and leave one cycle later over a second valid/ready channel, through a single output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput when the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the result is held and no new request is taken.

Top module: `pfe_eval`

## Requirements
- R1: Lane i of each operand and result word occupies bits 2i+1 (upper) and 2i (lower). Code 00 means 0, 11 means 1 and 10 means unknown (X). An input lane carrying 01 is treated as X, and no result lane is ever 01.
- R2: Gate codes 0 (AND), 1 (OR), 2 (NAND) and 3 (NOR) follow three-valued rules lane by lane. A controlling input value (0 for AND/NAND, 1 for OR/NOR) decides the result even when the other input is X. Otherwise any X input gives X.
- R3: Gate codes 4 (XOR) and 5 (XNOR) give X in any lane where either input is X, and the exact result elsewhere.
- R4: Gate code 6 (NOT) inverts operand A lane-wise, with X staying X, and ignores operand B. Code 7 gives X in every lane.
- R5: For lanes 1 to 15, a set bit in `sa1_mask` forces the result lane to 1. A set bit in `sa0_mask` forces it to 0. When both bits are set, stuck-at-1 wins. Bit 0 of both masks is ignored, so lane 0 always carries the fault-free result.
- R6: `out_detect` bit i is 1 only when lane i (i at least 1) and lane 0 both hold known values and those values differ. Bit 0 is always 0.
- R7: `out_err` is 1 when any lane of operand A or operand B carried the code 01, and is 0 otherwise.
- R8: A request is accepted on an edge with `in_valid` and `in_ready` both high, and its result appears with `out_valid` after that edge. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word`, `out_detect` and `out_err` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_a | input | 32 | Operand A, two bits per lane |
| in_b | input | 32 | Operand B, two bits per lane |
| in_gate | input | 3 | Gate type code |
| sa0_mask | input | 16 | Per-lane output stuck-at-0 |
| sa1_mask | input | 16 | Per-lane output stuck-at-1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Result word, two bits per lane |
| out_detect | output | 16 | Faulty lanes that differ from the good lane |
| out_err | output | 1 | An operand carried the illegal code |

## Verification
A wrong gate rule or a wrong fault-forcing path appears in `out_word` of the very transfer that uses it, one cycle after acceptance. A fault in the detection logic shows up in `out_detect` of that same transfer. The bench therefore checks each result as soon as it appears, against a lane-by-lane model. A broken hold register or a broken ready rule is visible within one cycle of a stall or a back-to-back transfer. This is caught by checking that results stay stable during held cycles, and by checking `in_ready` and `out_valid` around every transfer.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [2:0] {
    GT_AND  = 3'd0,
    GT_OR   = 3'd1,
    GT_NAND = 3'd2,
    GT_NOR  = 3'd3,
    GT_XOR  = 3'd4,
    GT_XNOR = 3'd5,
    GT_NOT  = 3'd6,
    GT_RSVD = 3'd7
  } gate_e;
endpackage

// File: rtl/pfe_split.sv
// Splits a packed operand word into "may be 1" and "is 1" planes and
// turns the illegal code into X.
module pfe_split #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic [W-1:0]     word,
  output logic [LANES-1:0] may1,
  output logic [LANES-1:0] is1,
  output logic             bad
);
  logic [LANES-1:0] up, dn;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign up[i] = word[2*i+1];
    assign dn[i] = word[2*i];
  end
  // 01 -> 10 (X); legal codes pass unchanged
  assign may1 = up | dn;
  assign is1  = up & dn;
  assign bad  = |(~up & dn);
endmodule

// File: rtl/pfe_logic.sv
// Lane-wise three-valued gate built from AND/OR/NOT on both planes.
module pfe_logic #(
  parameter int LANES = 16
) (
  input  pfe_pkg::gate_e   gate,
  input  logic [LANES-1:0] a_m, a_k,
  input  logic [LANES-1:0] b_m, b_k,
  output logic [LANES-1:0] r_m, r_k
);
  import pfe_pkg::*;
  logic [LANES-1:0] and_m, and_k, or_m, or_k;
  logic [LANES-1:0] na_m, na_k, nb_m, nb_k, xor_m, xor_k;

  always_comb begin
    and_m = a_m & b_m;
    and_k = a_k & b_k;
    or_m  = a_m | b_m;
    or_k  = a_k | b_k;
    na_m  = ~a_k;
    na_k  = ~a_m;
    nb_m  = ~b_k;
    nb_k  = ~b_m;
    // (a & ~b) | (~a & b)
    xor_m = (a_m & nb_m) | (na_m & b_m);
    xor_k = (a_k & nb_k) | (na_k & b_k);
    unique case (gate)
      GT_AND:  begin r_m = and_m;  r_k = and_k;  end
      GT_OR:   begin r_m = or_m;   r_k = or_k;   end
      GT_NAND: begin r_m = ~and_k; r_k = ~and_m; end
      GT_NOR:  begin r_m = ~or_k;  r_k = ~or_m;  end
      GT_XOR:  begin r_m = xor_m;  r_k = xor_k;  end
      GT_XNOR: begin r_m = ~xor_k; r_k = ~xor_m; end
      GT_NOT:  begin r_m = na_m;   r_k = na_k;   end
      default: begin r_m = '1;     r_k = '0;     end
    endcase
  end
endmodule

// File: rtl/pfe_fault.sv
// Forces faulty lanes to constants and compares them with the good lane.
module pfe_fault #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic [LANES-1:0] r_m, r_k,
  input  logic [LANES-1:0] sa0,
  input  logic [LANES-1:0] sa1,
  output logic [W-1:0]     word,
  output logic [LANES-1:0] detect
);
  localparam logic [LANES-1:0] FAULTY = ~LANES'(1);
  logic [LANES-1:0] f1, f0, m, k, known, diff;

  assign f1 = sa1 & FAULTY;
  assign f0 = sa0 & FAULTY & ~f1;
  assign m  = (r_m & ~f0) | f1;
  assign k  = (r_k & ~f0) | f1;

  assign known  = ~(m ^ k);
  assign diff   = k ^ {LANES{k[0]}};
  assign detect = known & {LANES{known[0]}} & diff & FAULTY;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign word[2*i+1] = m[i];
    assign word[2*i]   = k[i];
  end
endmodule

// File: rtl/pfe_eval.sv
module pfe_eval #(
  parameter int LANES = 16,
  localparam int W = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [2:0]       in_gate,
  input  logic [LANES-1:0] sa0_mask,
  input  logic [LANES-1:0] sa1_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_word,
  output logic [LANES-1:0] out_detect,
  output logic             out_err
);
  import pfe_pkg::*;
  logic [LANES-1:0] a_m, a_k, b_m, b_k, r_m, r_k, det_c;
  logic             a_bad, b_bad;
  logic [W-1:0]     word_c;

  pfe_split #(.LANES(LANES)) u_sa (.word(in_a), .may1(a_m), .is1(a_k), .bad(a_bad));
  pfe_split #(.LANES(LANES)) u_sb (.word(in_b), .may1(b_m), .is1(b_k), .bad(b_bad));

  pfe_logic #(.LANES(LANES)) u_lg (
    .gate(gate_e'(in_gate)), .a_m(a_m), .a_k(a_k), .b_m(b_m), .b_k(b_k),
    .r_m(r_m), .r_k(r_k));

  pfe_fault #(.LANES(LANES)) u_ft (
    .r_m(r_m), .r_k(r_k), .sa0(sa0_mask), .sa1(sa1_mask),
    .word(word_c), .detect(det_c));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_detect <= '0;
      out_err    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word   <= word_c;
        out_detect <= det_c;
        out_err    <= a_bad | b_bad;
      end
    end
  end

  // Checks on the registered result, decoded independently of the datapath
  logic [LANES-1:0] o_known, o_illegal;
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign o_known[i]   = out_word[2*i+1] == out_word[2*i];
    assign o_illegal[i] = !out_word[2*i+1] && out_word[2*i];
  end

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)
      && $stable(out_detect) && $stable(out_err));
  // R6
  detect_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_detect & ~o_known) == '0) && !out_detect[0]);
  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> o_illegal == '0);
endmodule

// File: tb/sim_pfe_eval.sv
module sim_pfe_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [2:0]  in_gate = '0;
  logic [15:0] sa0_mask = '0, sa1_mask = '0;
  logic        in_ready, out_valid, out_err;
  logic [31:0] out_word;
  logic [15:0] out_detect;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  pfe_eval u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_gate(in_gate), .sa0_mask(sa0_mask),
    .sa1_mask(sa1_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_detect(out_detect), .out_err(out_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // 0,1 known; 2 = X
  function automatic int dec(logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b11) return 1;
    return 2;
  endfunction
  function automatic logic [1:0] enc(int v);
    return v == 0 ? 2'b00 : (v == 1 ? 2'b11 : 2'b10);
  endfunction
  function automatic int f_and(int x, int y);
    if (x == 0 || y == 0) return 0;
    return (x == 1 && y == 1) ? 1 : 2;
  endfunction
  function automatic int f_or(int x, int y);
    if (x == 1 || y == 1) return 1;
    return (x == 0 && y == 0) ? 0 : 2;
  endfunction
  function automatic int f_not(int x);
    return x == 2 ? 2 : 1 - x;
  endfunction
  function automatic int f_xor(int x, int y);
    return (x == 2 || y == 2) ? 2 : (x ^ y);
  endfunction

  function automatic void model(input logic [31:0] a, b, input logic [2:0] g,
      input logic [15:0] s0, s1, output logic [31:0] w, output logic [15:0] d,
      output logic e);
    int v[16];
    e = 1'b0;
    for (int i = 0; i < 16; i++) begin
      int x, y, r;
      if (a[2*i+:2] == 2'b01 || b[2*i+:2] == 2'b01) e = 1'b1;
      x = dec(a[2*i+:2]);
      y = dec(b[2*i+:2]);
      case (g)
        3'd0: r = f_and(x, y);
        3'd1: r = f_or(x, y);
        3'd2: r = f_not(f_and(x, y));
        3'd3: r = f_not(f_or(x, y));
        3'd4: r = f_xor(x, y);
        3'd5: r = f_not(f_xor(x, y));
        3'd6: r = f_not(x);
        default: r = 2;
      endcase
      if (i > 0 && s1[i]) r = 1;
      else if (i > 0 && s0[i]) r = 0;
      v[i] = r;
      w[2*i+:2] = enc(r);
    end
    for (int i = 0; i < 16; i++)
      d[i] = (i > 0 && v[i] != 2 && v[0] != 2 && v[i] != v[0]);
  endfunction

  function automatic string greq(logic [2:0] g);
    if (g < 4) return "R2";
    if (g < 6) return "R3";
    return "R4";
  endfunction

  task automatic xfer(input logic [31:0] a, b, input logic [2:0] g,
      input logic [15:0] s0, s1, input int stall, input string wreq);
    logic [31:0] ew; logic [15:0] ed; logic ee;
    model(a, b, g, s0, s1, ew, ed, ee);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_a = a; in_b = b; in_gate = g; sa0_mask = s0; sa1_mask = s1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R8", 32'(in_ready), 32'd0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_word == ew, "R9", out_word, ew);
    end
    chk(out_word == ew, wreq, out_word, ew);
    chk(out_detect == ed, "R6", 32'(out_detect), 32'(ed));
    chk(out_err == ee, "R7", 32'(out_err), 32'(ee));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8", 32'(out_valid), 32'd0);
  endtask

  function automatic logic [31:0] legal_word(logic [31:0] r);
    logic [31:0] w;
    for (int i = 0; i < 16; i++) w[2*i+:2] = (r[2*i+:2] == 2'b01) ? 2'b00 : r[2*i+:2];
    return w;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected below 150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] ew, ew2; logic [15:0] ed; logic ee;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R10", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // R1: 01 codes on A under NOT read as X; B ignored (R4)
    xfer(32'h5555_5555, 32'h0, 3'd6, 16'h0, 16'h0, 0, "R1");
    // R2: AND with X against 0 -> 0, X against 1 -> X
    xfer({16{2'b10}}, {8{4'b0011}}, 3'd0, 16'h0, 16'h0, 1, "R2");
    // R2: OR with X against 1 -> 1
    xfer({16{2'b10}}, {8{4'b0011}}, 3'd1, 16'h0, 16'h0, 0, "R2");
    // R3: XOR with X -> X
    xfer({16{2'b10}}, {16{2'b11}}, 3'd4, 16'h0, 16'h0, 0, "R3");
    // R4: reserved code -> all X
    xfer(32'hFFFF_FFFF, 32'h0, 3'd7, 16'h0, 16'h0, 0, "R4");
    // R5: both masks set -> stuck-at-1 wins; lane 0 masks ignored
    xfer(32'h0, 32'h0, 3'd1, 16'hFFFF, 16'h00F1, 2, "R5");
    // R6: good lane X -> no detection anywhere
    xfer({16{2'b10}}, {16{2'b11}}, 3'd0, 16'h0F0E, 16'h00F0, 0, "R6");

    // R8: back-to-back with out_ready high
    model(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, 16'h0002, 16'h0, ew, ed, ee);
    model(32'h0, 32'h0, 3'd3, 16'h0, 16'h0, ew2, ed, ee);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_a = '1; in_b = '1; in_gate = 3'd0; sa0_mask = 16'h0002; sa1_mask = '0;
    @(negedge clk);
    chk(out_word == ew, "R8", out_word, ew);
    chk(in_ready == 1'b1, "R8", 32'(in_ready), 32'd1);
    in_a = '0; in_b = '0; in_gate = 3'd3; sa0_mask = '0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_word == ew2, "R8", out_word, ew2);
    @(negedge clk);
    out_ready = 1'b0;

    // random: mixed legal/illegal words, all gate codes, sparse masks
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b; logic [2:0] g;
      a = $urandom; b = $urandom; g = 3'($urandom);
      if (n % 2 == 0) begin a = legal_word(a); b = legal_word(b); end
      xfer(a, b, g, 16'($urandom & $urandom), 16'($urandom & $urandom & $urandom),
           int'($urandom % 3), greq(g));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule